// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a device. A board tester drives it serially with a test clock, a mode-select line and a data input, and it answers on a data output that drives only while a register is being shifted. A sixteen-state controller steps on every rising test-clock edge according to the mode-select level. The controller walks one of two branches: the instruction branch shifts a 2-bit instruction register, and the data branch shifts whichever data register the active instruction selects. The data registers are a one-bit bypass stage, a 32-bit identification word, or an external boundary chain.

The boundary cells themselves sit outside the block. The controller hands them capture, shift and update strobes, a serial input, and a mode flag. The mode flag moves the output pins from core control to chain control under the external-test instruction. The chain's serial output comes back into the block. The identification word is assembled from four parameter fields (version, part, derivative, maker) plus a fixed 1 in bit 0. With the default fields it reads 0x066E10C9.

The controller states are Test-Logic-Reset, Run-Test/Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR.

Top module: `scan_tap_ctrl`

## Requirements
- R1: On each rising tck edge the state follows the TMS level. Test-Logic-Reset goes 0→Run-Test/Idle, 1→itself. Run-Test/Idle goes 0→itself, 1→Select-DR. Select-DR goes 0→Capture-DR, 1→Select-IR. Select-IR goes 0→Capture-IR, 1→Test-Logic-Reset. In each branch, Capture goes 0→Shift, 1→Exit1. Shift goes 0→itself, 1→Exit1. Exit1 goes 0→Pause, 1→Update. Pause goes 0→itself, 1→Exit2. Exit2 goes 0→Shift, 1→Update. Both Update states go 0→Run-Test/Idle, 1→Select-DR.
- R2: Five or more consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state, and it stays there while TMS stays high.
- R3: The instruction register is 2 bits wide and is shifted LSB first from tdi toward tdo. In Capture-IR it loads the pattern 01, so the first bit out is 1 and the second is 0. Codes: 00 external test, 01 sample/preload, 10 identification, 11 bypass.
- R4: Whenever the controller is in Test-Logic-Reset, the identification instruction (10) is active. Under it, Capture-DR loads the 32-bit word 0x066E10C9 (version in bits 31:28, part 27:14, derivative 13:12, maker 11:1, bit 0 = 1), and Shift-DR sends it out LSB first.
- R5: Under bypass (11), the path from tdi to tdo is one register long. The register captures 0 in Capture-DR, so a shifted pattern comes out delayed by one bit behind a leading 0.
- R6: Under external test (00), bsr_mode is 1. The boundary chain is the selected data register: its captured contents come out on tdo, and tdi enters it through bsr_si.
- R7: Under sample/preload (01), bsr_mode is 0. The boundary chain is still selected and captures the pin values in Capture-DR.
- R8: tdo and tdo_oe change only on the falling tck edge. tdo_oe is 1 exactly in Shift-IR and Shift-DR.
- R9: A newly shifted instruction becomes active only at the falling edge in Update-IR. Until then, in Exit1-IR, the previous instruction stays in force.
- R10: bsr_capture, bsr_shift and bsr_update are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while a boundary instruction (00 or 01) is active. Under identification or bypass the chain's update latches are left unchanged.
- R11: trst_n low immediately forces Test-Logic-Reset and the identification instruction, clears tdo_oe and bsr_mode, and needs no tck edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (may be tied high) |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_si | output | 1 | Serial input to the boundary chain |
| bsr_so | input | 1 | Serial output returned from the boundary chain |
| bsr_capture | output | 1 | Boundary chain parallel capture strobe |
| bsr_shift | output | 1 | Boundary chain shift enable |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_mode | output | 1 | Output pins driven from the chain when 1 |

## Verification
The bench goes after three kinds of fault. The first is the five-high reset, reached from each of the sixteen states in turn: a controller that misses one path would leave a stale instruction, and the identification read that follows would return the wrong word. The second is instruction timing at Exit1-IR and after an asynchronous reset: a register that updates early shows the new bsr_mode one state too soon, and a reset that waits for a clock keeps external-test mode alive. The third is the per-cycle comparison against an arithmetic model over a long random walk. That walk catches a strobe issued under identification or bypass, which would overwrite the chain's update latches, and catches a tdo that switches on the rising edge or an enable that leaks into Exit or Pause states.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 2;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 2'b00,
        OP_SAMPLE = 2'b01,
        OP_IDCODE = 2'b10,
        OP_BYPASS = 2'b11
    } tap_op_e;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 2'b01;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // transitions
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_DR_SEL : ST_IDLE;
            ST_DR_SEL: nxt = tms ? ST_IR_SEL : ST_DR_CAP;
            ST_DR_CAP: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_SHF: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_EX1: nxt = tms ? ST_DR_UPD : ST_DR_PAU;
            ST_DR_PAU: nxt = tms ? ST_DR_EX2 : ST_DR_PAU;
            ST_DR_EX2: nxt = tms ? ST_DR_UPD : ST_DR_SHF;
            ST_DR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
            ST_IR_SEL: nxt = tms ? ST_RESET  : ST_IR_CAP;
            ST_IR_CAP: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_SHF: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_EX1: nxt = tms ? ST_IR_UPD : ST_IR_PAU;
            ST_IR_PAU: nxt = tms ? ST_IR_EX2 : ST_IR_PAU;
            ST_IR_EX2: nxt = tms ? ST_IR_UPD : ST_IR_SHF;
            ST_IR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
        endcase
    end

    // state decodes
    always_comb begin
        in_reset = (state == ST_RESET);
        cap_dr   = (state == ST_DR_CAP);
        shf_dr   = (state == ST_DR_SHF);
        upd_dr   = (state == ST_DR_UPD);
        cap_ir   = (state == ST_IR_CAP);
        shf_ir   = (state == ST_IR_SHF);
        upd_ir   = (state == ST_IR_UPD);
    end

endmodule

// File: rtl/scan_tap_ireg.sv
module scan_tap_ireg
    import scan_tap_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tdi,
    input  logic    in_reset,
    input  logic    cap_ir,
    input  logic    shf_ir,
    input  logic    upd_ir,
    output logic    ir_lsb,
    output tap_op_e op
);

    logic [IR_W-1:0] sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     sr <= IR_CAPTURE_PAT;
        else if (cap_ir) sr <= IR_CAPTURE_PAT;
        else if (shf_ir) sr <= {tdi, sr[IR_W-1:1]};
    end

    // active instruction moves on the falling edge only
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       op <= OP_IDCODE;
        else if (in_reset) op <= OP_IDCODE;
        else if (upd_ir)   op <= tap_op_e'(sr);
    end

    assign ir_lsb = sr[0];

endmodule

// File: rtl/scan_tap_dreg.sv
module scan_tap_dreg
    import scan_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
)(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tdi,
    input  logic    cap_dr,
    input  logic    shf_dr,
    input  tap_op_e op,
    output logic    byp_lsb,
    output logic    id_lsb
);

    logic            byp;
    logic [ID_W-1:0] id_sr;
    logic            sel_byp, sel_id;

    assign sel_byp = (op == OP_BYPASS);
    assign sel_id  = (op == OP_IDCODE);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp   <= 1'b0;
            id_sr <= ID_WORD;
        end else begin
            if (sel_byp && cap_dr) byp <= 1'b0;
            else if (sel_byp && shf_dr) byp <= tdi;
            if (sel_id && cap_dr) id_sr <= ID_WORD;
            else if (sel_id && shf_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    assign byp_lsb = byp;
    assign id_lsb  = id_sr[0];

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [13:0] ID_PART    = 14'h19B8,
    parameter logic [1:0]  ID_DERIV   = 2'h1,
    parameter logic [10:0] ID_MAKER   = 11'h064
)(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic bsr_si,
    input  logic bsr_so,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic bsr_mode
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_DERIV, ID_MAKER, 1'b1};

    tap_state_e state;
    tap_op_e    op;
    logic       in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    logic       ir_lsb, byp_lsb, id_lsb, dr_lsb, chain_sel;

    scan_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir)
    );

    scan_tap_ireg u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
        .ir_lsb(ir_lsb), .op(op)
    );

    scan_tap_dreg #(.ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .op(op), .byp_lsb(byp_lsb), .id_lsb(id_lsb)
    );

    assign chain_sel   = (op == OP_EXTEST) || (op == OP_SAMPLE);
    assign bsr_capture = cap_dr && chain_sel;
    assign bsr_shift   = shf_dr && chain_sel;
    assign bsr_update  = upd_dr && chain_sel;
    assign bsr_mode    = (op == OP_EXTEST);
    assign bsr_si      = tdi;

    always_comb begin
        unique case (op)
            OP_BYPASS: dr_lsb = byp_lsb;
            OP_IDCODE: dr_lsb = id_lsb;
            OP_EXTEST,
            OP_SAMPLE: dr_lsb = bsr_so;
        endcase
    end

    // output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shf_ir || shf_dr;
            tdo    <= shf_ir ? ir_lsb : dr_lsb;
        end
    end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_e state,
    input logic       tdo_oe,
    input logic       bsr_capture,
    input logic       bsr_update,
    input logic       bsr_mode
);

    logic [2:0] hi_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 hi_run <= 3'd0;
        else if (!tms)               hi_run <= 3'd0;
        else if (hi_run != 3'd5)     hi_run <= hi_run + 3'd1;
    end

    assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run == 3'd5) |-> (state == ST_RESET));

    assert_oe_window_R8: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((state == ST_IR_SHF) || (state == ST_DR_SHF)));

    assert_update_entry_R10: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_update |-> (($past(state) == ST_DR_EX1) || ($past(state) == ST_DR_EX2)));

    assert_capture_entry_R10: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_capture |-> ($past(state) == ST_DR_SEL));

    assert_mode_change_R9: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(bsr_mode) |-> ((state == ST_IR_UPD) || (state == ST_RESET)));

    assert_reset_idcode_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |-> !bsr_mode);

endmodule

bind scan_tap_ctrl scan_tap_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .tdo_oe(tdo_oe),
    .bsr_capture(bsr_capture), .bsr_update(bsr_update), .bsr_mode(bsr_mode)
);

// File: tb/sim_scan_tap_ctrl.sv
module sim_scan_tap_ctrl;

    localparam int L = 8;
    localparam logic [31:0] ID = 32'h066E10C9;
    localparam int S_TLR = 0, S_RTI = 1, S_SDS = 2, S_CDR = 3, S_SDR = 4, S_E1D = 5,
                   S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIS = 9, S_CIR = 10, S_SIR = 11,
                   S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, bsr_si, bsr_so, bsr_capture, bsr_shift, bsr_update, bsr_mode;
    logic [L-1:0] chain = '0, upd = '0, pins = '0;

    int total = 0, bad = 0;
    int ms;
    logic [1:0] msr, mact;
    logic mbyp;
    logic [31:0] mid;
    logic [L-1:0] mch = '0, mupd = '0;

    always #4 tck = ~tck;

    scan_tap_ctrl u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .bsr_si(bsr_si), .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_mode(bsr_mode)
    );

    // external boundary chain
    always @(posedge tck) begin
        if (bsr_capture)    chain <= pins;
        else if (bsr_shift) chain <= {bsr_si, chain[L-1:1]};
    end
    always @(negedge tck) if (bsr_update) upd <= chain;
    assign bsr_so = chain[0];

    function automatic int nxt(input int s, input logic t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDS : S_RTI;
            S_SDS: return t ? S_SIS : S_CDR;
            S_CDR, S_SDR: return t ? S_E1D : S_SDR;
            S_E1D: return t ? S_UDR : S_PDR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_E2D: return t ? S_UDR : S_SDR;
            S_SIS: return t ? S_TLR : S_CIR;
            S_CIR, S_SIR: return t ? S_E1I : S_SIR;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PIR: return t ? S_E2I : S_PIR;
            S_E2I: return t ? S_UIR : S_SIR;
            default: return t ? S_SDS : S_RTI;
        endcase
    endfunction

    function automatic logic bnd(input logic [1:0] a);
        return (a == 2'b00) || (a == 2'b01);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic model_reset();
        ms = S_TLR; msr = 2'b01; mact = 2'b10; mbyp = 1'b0; mid = ID;
    endtask

    task automatic tick(input logic t, input logic d, output logic q);
        logic [L+5:0] act, exp;
        logic e_oe, e_tdo;
        e_oe = (ms == S_SIR) || (ms == S_SDR);
        if (ms == S_SIR)      e_tdo = msr[0];
        else if (ms == S_SDR) e_tdo = (mact == 2'b11) ? mbyp : (mact == 2'b10) ? mid[0] : mch[0];
        else                  e_tdo = 1'b0;
        act = {upd, tdo_oe, tdo_oe & tdo, bsr_capture, bsr_shift, bsr_update, bsr_mode};
        exp = {mupd, e_oe, e_oe & e_tdo, (ms == S_CDR) && bnd(mact), (ms == S_SDR) && bnd(mact),
               (ms == S_UDR) && bnd(mact), mact == 2'b00};
        check(act == exp, "R1 R8 R10 per-cycle", 64'(act), 64'(exp));
        q = tdo;
        tms = t; tdi = d;
        @(posedge tck);
        case (ms)
            S_CIR: msr = 2'b01;
            S_SIR: msr = {d, msr[1]};
            S_CDR: if (mact == 2'b11) mbyp = 1'b0; else if (mact == 2'b10) mid = ID; else mch = pins;
            S_SDR: if (mact == 2'b11) mbyp = d; else if (mact == 2'b10) mid = {d, mid[31:1]};
                   else mch = {d, mch[L-1:1]};
            default: ;
        endcase
        ms = nxt(ms, t);
        if (ms == S_UIR) mact = msr;
        if (ms == S_TLR) mact = 2'b10;
        if (ms == S_UDR && bnd(mact)) mupd = mch;
        @(negedge tck); #1;
    endtask

    // from Run-Test/Idle back to Run-Test/Idle
    task automatic load_ir(input logic [1:0] code, output logic [1:0] cap, output logic mode_e1);
        logic q;
        tick(1, 0, q); tick(1, 0, q); tick(0, 0, q); tick(0, 0, q);
        tick(0, code[0], cap[0]);
        tick(1, code[1], cap[1]);
        mode_e1 = bsr_mode;
        tick(1, 0, q); tick(0, 0, q);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic q;
        dout = '0;
        tick(1, 0, q); tick(0, 0, q); tick(0, 0, q);
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i], dout[i]);
        tick(1, 0, q); tick(0, 0, q);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic q, me;
        logic [1:0] cap;
        logic [63:0] dout;
        model_reset();
        repeat (3) @(negedge tck);
        #1 trst_n = 1'b1;
        check({tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_mode} == 5'b0, "R11 reset state",
              64'({tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_mode}), 0);
        tick(0, 0, q);

        // R4: identification word after reset
        scan_dr(32, 64'h0, dout);
        check(dout[31:0] == ID, "R4 id word", dout, 64'(ID));

        // R3 capture pattern, R5 bypass delay
        load_ir(2'b11, cap, me);
        check(cap == 2'b01, "R3 ir capture", 64'(cap), 64'h1);
        scan_dr(8, 64'hA5, dout);
        check(dout[7:0] == 8'h4A, "R5 bypass", dout, 64'h4A);

        // R6 external test, R9 timing of update
        pins = 8'h3C;
        load_ir(2'b00, cap, me);
        check(me == 1'b0, "R9 old op at Exit1-IR", 64'(me), 0);
        check(bsr_mode == 1'b1, "R6 mode on", 64'(bsr_mode), 1);
        scan_dr(8, 64'hC3, dout);
        check(dout[7:0] == 8'h3C, "R6 chain capture", dout, 64'h3C);
        check(upd == 8'hC3, "R10 chain update", 64'(upd), 64'hC3);

        // R7 sample/preload
        load_ir(2'b01, cap, me);
        check(me == 1'b1, "R9 extest held at Exit1-IR", 64'(me), 1);
        check(bsr_mode == 1'b0, "R7 mode off", 64'(bsr_mode), 0);
        pins = 8'h5A;
        scan_dr(8, 64'h11, dout);
        check(dout[7:0] == 8'h5A, "R7 pin sample", dout, 64'h5A);
        check(upd == 8'h11, "R7 preload", 64'(upd), 64'h11);

        // R10: identification leaves the chain latches alone
        load_ir(2'b10, cap, me);
        scan_dr(8, 64'hFF, dout);
        check(dout[7:0] == 8'hC9, "R4 id low byte", dout, 64'hC9);
        check(upd == 8'h11, "R10 no update under id", 64'(upd), 64'h11);
        load_ir(2'b11, cap, me);
        scan_dr(8, 64'hEE, dout);
        check(upd == 8'h11, "R10 no update under bypass", 64'(upd), 64'h11);

        // R11: asynchronous reset in the middle of a cycle
        load_ir(2'b00, cap, me);
        tick(1, 0, q); tick(0, 0, q); tick(0, 0, q);
        #1 trst_n = 1'b0;
        #1 check({bsr_mode, tdo_oe, bsr_shift} == 3'b0, "R11 async clear",
                 64'({bsr_mode, tdo_oe, bsr_shift}), 0);
        @(negedge tck); #1 trst_n = 1'b1;
        model_reset();
        tick(0, 0, q);
        scan_dr(32, 64'h0, dout);
        check(dout[31:0] == ID, "R11 id after async reset", dout, 64'(ID));

        // R2: five TMS-high edges from every state
        for (int t = 0; t < 16; t++) begin
            load_ir(2'b00, cap, me);
            for (int k = 0; k < 400 && ms != t; k++) tick(1'($urandom & 1), 1'($urandom & 1), q);
            repeat (8) tick(1, 1'($urandom & 1), q);
            check(bsr_mode == 1'b0 && tdo_oe == 1'b0, "R2 held in reset",
                  64'({bsr_mode, tdo_oe}), 0);
            tick(0, 0, q);
            scan_dr(32, 64'h0, dout);
            check(dout[31:0] == ID, $sformatf("R2 reset from state %0d", t), dout, 64'(ID));
        end

        // R1 R8 R10: random walk against the model
        for (int k = 0; k < 4000; k++) begin
            if ((k % 16) == 0) pins = L'($urandom);
            tick(1'($urandom & 1), 1'($urandom & 1), q);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule